// File: doc/BRIEF.md
# NAND Target Command and Address Decoder

This block is the device-side control logic of a single NAND target. The host presents one chunk per strobe, together with a type: a command byte, an address byte, a write-data byte or a read request. The block keeps the current command, a confirm register, five address slots with a load pointer, and a column counter. From the column and the active LUN it gates data bytes into, and out of, a small per-LUN page register that stands in for the array. A read request returns either page data or the active LUN's status byte, depending on the command state.

The command chosen presets the address pointer. Read and Program need all five slots, Erase needs the three row slots only, and Status, like Reset, needs none. Once the pointer is full, a second command chunk is taken as the confirm of a Read, Program or Erase. The confirm value then decides whether data may flow, and in which direction. A chunk that breaks any of these rules is dropped and raises a sticky protocol-error flag. The next accepted command clears the flag.

Top module: `nand_tgt_decoder`

## Requirements
- R1: After reset, both the command register and the confirm register hold Reset and the pointer holds 5. `proto_err`, `rd_data`, `col_addr` and the decoded page, block and LUN fields are all 0. Every LUN status byte is 8'h40.
- R2: Command byte codes are Reset 8'hFF, Status 8'h70, Read 8'h00, Program 8'h80 and Erase 8'h60. A command chunk that is not taken as a confirm stores its command and clears confirm to Reset. It sets the pointer to 5 for Reset and Status, to 0 for Read and Program, and to 2 for Erase.
- R3: An address chunk (chunk type 1) is accepted only while the pointer is below 5. It is stored in the slot the pointer names, and the pointer then increments.
- R4: When slot 4 is written, the column loads from the low `COL_W` bits of {slot1, slot0}. Slots 0 and 1 keep whatever they last held. The row {slot4, slot3, slot2} decodes, from bit 0 upward, into page (`PAGE_W` bits), block (`BLK_W` bits) and LUN (`LUN_W` bits). The LUN field at that moment becomes the active LUN.
- R5: A command chunk is taken as a confirm only when the pointer is 5, the stored command is Read, Program or Erase, confirm is still Reset, and the byte is not Reset. Confirm then takes the byte's command. Any other valid command chunk starts a new command.
- R6: A write-data chunk (type 2) is accepted only when confirm is Program. It stores the byte in the active LUN's page register at the column, and the column then increments, wrapping at 2^COL_W.
- R7: A read chunk (type 3), when confirm is Read, sets `rd_data` on the next edge to the active LUN's page byte at the column. The column then increments, wrapping at 2^COL_W.
- R8: A read chunk, when the command is Status or confirm is Status, sets `rd_data` to the active LUN's status byte and leaves the column unchanged. The status byte is 8'h40 OR a code in bits 2:0. The code is that of the command confirmed last on that LUN: 1 Read, 2 Program, 3 Erase.
- R9: A chunk that breaks its precondition, and a command byte with no defined code, are ignored: no register or page byte changes. Such a chunk sets `proto_err`, which stays set until a valid command chunk is accepted.
- R10: Each LUN has its own page register and status code, and these are selected by the active LUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chunk_vld | input | 1 | Chunk strobe, one chunk per cycle |
| chunk_kind | input | 2 | Chunk type: 0 command, 1 address, 2 write data, 3 read request |
| chunk_byte | input | 8 | Chunk payload |
| rd_data | output | 8 | Registered read result |
| proto_err | output | 1 | Sticky protocol-error flag |
| col_addr | output | COL_W | Column counter |
| page_addr | output | PAGE_W | Decoded page field |
| block_addr | output | BLK_W | Decoded block field |
| lun_addr | output | LUN_W | Decoded LUN field |

## Verification
Every result is due one clock edge after its chunk is sampled. The pointer, confirm and error flag, the column, the decoded fields and `rd_data` all update on that edge, and nothing is pipelined further. The bench drives each chunk from one falling edge to the next. It samples at that second falling edge, half a period after the capturing edge. At that point both the registered outputs and the fields decoded from them have settled. Rejected chunks are checked in the same cycle, by confirming that the column and `rd_data` held and that the flag rose. Rejected writes are then read back later to show that the page bytes are untouched.

// File: rtl/nand_tgt_pkg.sv
package nand_tgt_pkg;

  typedef enum logic [2:0] {
    CMD_RESET  = 3'd0,
    CMD_STATUS = 3'd1,
    CMD_READ   = 3'd2,
    CMD_PROG   = 3'd3,
    CMD_ERASE  = 3'd4
  } cmd_e;

  localparam logic [1:0] KIND_CMD   = 2'd0;
  localparam logic [1:0] KIND_ADDR  = 2'd1;
  localparam logic [1:0] KIND_WDATA = 2'd2;
  localparam logic [1:0] KIND_RDATA = 2'd3;

  localparam int unsigned SLOTS = 5;
  localparam int unsigned PTR_W = 3;
  localparam logic [PTR_W-1:0] PTR_FULL = 3'd5;

  typedef struct packed {
    logic ok;
    cmd_e op;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [7:0] b);
    cmd_dec_t r;
    r.ok = 1'b1;
    case (b)
      8'hFF:   r.op = CMD_RESET;
      8'h70:   r.op = CMD_STATUS;
      8'h00:   r.op = CMD_READ;
      8'h80:   r.op = CMD_PROG;
      8'h60:   r.op = CMD_ERASE;
      default: begin
        r.ok = 1'b0;
        r.op = CMD_RESET;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nand_tgt_ctl.sv
module nand_tgt_ctl
  import nand_tgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chunk_vld,
  input  logic [1:0]       chunk_kind,
  input  logic [7:0]       chunk_byte,
  output logic [PTR_W-1:0] ptr_q,
  output cmd_e             cmd_q,
  output cmd_e             cfm_q,
  output logic             err_q,
  output logic             addr_we,
  output logic             wr_acc,
  output logic             rd_page,
  output logic             rd_stat,
  output logic             cfm_acc,
  output logic [1:0]       cfm_code
);

  logic [PTR_W-1:0] ptr_d;
  cmd_e             cmd_d;
  cmd_e             cfm_d;
  logic             err_d;
  cmd_dec_t         dec;
  logic             pend_cfm;
  logic             dbl_cmd;

  always_comb begin
    dec      = decode_cmd(chunk_byte);
    dbl_cmd  = (cmd_q == CMD_READ) || (cmd_q == CMD_PROG) || (cmd_q == CMD_ERASE);
    pend_cfm = (ptr_q == PTR_FULL) && dbl_cmd && (cfm_q == CMD_RESET);
    ptr_d    = ptr_q;
    cmd_d    = cmd_q;
    cfm_d    = cfm_q;
    err_d    = err_q;
    addr_we  = 1'b0;
    wr_acc   = 1'b0;
    rd_page  = 1'b0;
    rd_stat  = 1'b0;
    cfm_acc  = 1'b0;
    if (chunk_vld) begin
      case (chunk_kind)
        KIND_CMD: begin
          if (!dec.ok) begin
            err_d = 1'b1;
          end else if (pend_cfm && (dec.op != CMD_RESET)) begin
            cfm_d   = dec.op;
            err_d   = 1'b0;
            cfm_acc = 1'b1;
          end else begin
            cmd_d = dec.op;
            cfm_d = CMD_RESET;
            err_d = 1'b0;
            case (dec.op)
              CMD_READ, CMD_PROG: ptr_d = 3'd0;
              CMD_ERASE:          ptr_d = 3'd2;
              default:            ptr_d = PTR_FULL;
            endcase
          end
        end
        KIND_ADDR: begin
          if (ptr_q < PTR_FULL) begin
            addr_we = 1'b1;
            ptr_d   = ptr_q + 3'd1;
          end else begin
            err_d = 1'b1;
          end
        end
        KIND_WDATA: begin
          if (cfm_q == CMD_PROG) wr_acc = 1'b1;
          else                   err_d  = 1'b1;
        end
        default: begin
          if ((cmd_q == CMD_STATUS) || (cfm_q == CMD_STATUS)) rd_stat = 1'b1;
          else if (cfm_q == CMD_READ)                         rd_page = 1'b1;
          else                                                err_d   = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    case (cmd_q)
      CMD_READ:  cfm_code = 2'd1;
      CMD_PROG:  cfm_code = 2'd2;
      CMD_ERASE: cfm_code = 2'd3;
      default:   cfm_code = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_FULL;
      cmd_q <= CMD_RESET;
      cfm_q <= CMD_RESET;
      err_q <= 1'b0;
    end else if (chunk_vld) begin
      ptr_q <= ptr_d;
      cmd_q <= cmd_d;
      cfm_q <= cfm_d;
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/nand_tgt_addr.sv
module nand_tgt_addr
  import nand_tgt_pkg::*;
#(
  parameter int unsigned COL_W  = 4,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned LUN_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [PTR_W-1:0]  slot,
  input  logic [7:0]        byte_in,
  input  logic              col_inc,
  output logic [COL_W-1:0]  col_q,
  output logic [PAGE_W-1:0] page,
  output logic [BLK_W-1:0]  block,
  output logic [LUN_W-1:0]  lun,
  output logic [LUN_W-1:0]  act_lun_q
);

  localparam int unsigned ROW_W  = 24;
  localparam int unsigned BLK_SH = PAGE_W;
  localparam int unsigned LUN_SH = PAGE_W + BLK_W;

  logic [7:0]        areg_q [SLOTS];
  logic [ROW_W-1:0]  row;
  logic [ROW_W-1:0]  row_next;
  logic [COL_W-1:0]  col_d;
  logic [LUN_W-1:0]  act_lun_d;
  logic              last_slot;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   areg_q[s] <= 8'h00;
      else if (addr_we && (slot == PTR_W'(s)))      areg_q[s] <= byte_in;
    end
  end

  always_comb begin
    row       = {areg_q[4], areg_q[3], areg_q[2]};
    row_next  = {byte_in, areg_q[3], areg_q[2]};
    page      = PAGE_W'(row);
    block     = BLK_W'(row >> BLK_SH);
    lun       = LUN_W'(row >> LUN_SH);
    last_slot = addr_we && (slot == 3'd4);
    col_d     = col_q;
    act_lun_d = act_lun_q;
    if (last_slot) begin
      col_d     = COL_W'({areg_q[1], areg_q[0]});
      act_lun_d = LUN_W'(row_next >> LUN_SH);
    end else if (col_inc) begin
      col_d = col_q + {{(COL_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      act_lun_q <= '0;
    end else if (last_slot || col_inc) begin
      col_q     <= col_d;
      act_lun_q <= act_lun_d;
    end
  end

endmodule

// File: rtl/nand_tgt_pgbuf.sv
module nand_tgt_pgbuf #(
  parameter int unsigned COL_W = 4,
  parameter int unsigned LUN_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_acc,
  input  logic             rd_page,
  input  logic             rd_stat,
  input  logic             cfm_acc,
  input  logic [1:0]       cfm_code,
  input  logic [LUN_W-1:0] act_lun,
  input  logic [COL_W-1:0] col,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_data
);

  localparam int unsigned NUM_LUNS = 1 << LUN_W;
  localparam int unsigned DEPTH    = 1 << COL_W;

  logic [7:0] mem_q  [NUM_LUNS][DEPTH];
  logic [1:0] code_q [NUM_LUNS];
  logic [7:0] rd_d;

  always_ff @(posedge clk) begin
    if (wr_acc) mem_q[act_lun][col] <= wdata;
  end

  for (genvar l = 0; l < NUM_LUNS; l++) begin : g_lun
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  code_q[l] <= 2'd0;
      else if (cfm_acc && (act_lun == LUN_W'(l)))  code_q[l] <= cfm_code;
    end
  end

  always_comb begin
    rd_d = rd_data;
    if (rd_page)      rd_d = mem_q[act_lun][col];
    else if (rd_stat) rd_d = {6'b010000, code_q[act_lun]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rd_data <= 8'h00;
    else if (rd_page || rd_stat) rd_data <= rd_d;
  end

endmodule

// File: rtl/nand_tgt_decoder.sv
module nand_tgt_decoder
  import nand_tgt_pkg::*;
#(
  parameter int unsigned COL_W  = 4,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned LUN_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chunk_vld,
  input  logic [1:0]        chunk_kind,
  input  logic [7:0]        chunk_byte,
  output logic [7:0]        rd_data,
  output logic              proto_err,
  output logic [COL_W-1:0]  col_addr,
  output logic [PAGE_W-1:0] page_addr,
  output logic [BLK_W-1:0]  block_addr,
  output logic [LUN_W-1:0]  lun_addr
);

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [PTR_W-1:0] ptr;
  cmd_e             cmd_st;
  cmd_e             cfm_st;
  logic             addr_we;
  logic             wr_acc;
  logic             rd_page;
  logic             rd_stat;
  logic             cfm_acc;
  logic [1:0]       cfm_code;
  logic [LUN_W-1:0] act_lun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  nand_tgt_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .chunk_vld  (chunk_vld),
    .chunk_kind (chunk_kind),
    .chunk_byte (chunk_byte),
    .ptr_q      (ptr),
    .cmd_q      (cmd_st),
    .cfm_q      (cfm_st),
    .err_q      (proto_err),
    .addr_we    (addr_we),
    .wr_acc     (wr_acc),
    .rd_page    (rd_page),
    .rd_stat    (rd_stat),
    .cfm_acc    (cfm_acc),
    .cfm_code   (cfm_code)
  );

  nand_tgt_addr #(
    .COL_W  (COL_W),
    .PAGE_W (PAGE_W),
    .BLK_W  (BLK_W),
    .LUN_W  (LUN_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr_we   (addr_we),
    .slot      (ptr),
    .byte_in   (chunk_byte),
    .col_inc   (wr_acc || rd_page),
    .col_q     (col_addr),
    .page      (page_addr),
    .block     (block_addr),
    .lun       (lun_addr),
    .act_lun_q (act_lun)
  );

  nand_tgt_pgbuf #(
    .COL_W (COL_W),
    .LUN_W (LUN_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_acc   (wr_acc),
    .rd_page  (rd_page),
    .rd_stat  (rd_stat),
    .cfm_acc  (cfm_acc),
    .cfm_code (cfm_code),
    .act_lun  (act_lun),
    .col      (col_addr),
    .wdata    (chunk_byte),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/nand_tgt_decoder_chk.sv
module nand_tgt_decoder_chk
  import nand_tgt_pkg::*;
#(
  parameter int unsigned COL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chunk_vld,
  input logic [1:0]       chunk_kind,
  input logic [7:0]       chunk_byte,
  input logic [PTR_W-1:0] ptr,
  input cmd_e             cmd_st,
  input cmd_e             cfm_st,
  input logic             proto_err,
  input logic [COL_W-1:0] col_addr,
  input logic [7:0]       rd_data
);

  logic pend;
  logic known;
  assign pend  = (ptr == PTR_FULL) && (cfm_st == CMD_RESET) &&
                 ((cmd_st == CMD_READ) || (cmd_st == CMD_PROG) || (cmd_st == CMD_ERASE));
  assign known = (chunk_byte == 8'hFF) || (chunk_byte == 8'h70) || (chunk_byte == 8'h00) ||
                 (chunk_byte == 8'h80) || (chunk_byte == 8'h60);

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_FULL);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && chunk_kind == KIND_ADDR && ptr < PTR_FULL) |=> (ptr == $past(ptr) + 3'd1));

  assert_addr_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && chunk_kind == KIND_ADDR && ptr == PTR_FULL) |=> (proto_err && $stable(ptr)));

  assert_status_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && chunk_kind == KIND_CMD && chunk_byte == 8'h70 && !pend)
      |=> (ptr == PTR_FULL && cfm_st == CMD_RESET));

  assert_read_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && chunk_kind == KIND_CMD && chunk_byte == 8'h00 && !pend) |=> (ptr == 3'd0));

  assert_wr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && chunk_kind == KIND_WDATA && cfm_st != CMD_PROG)
      |=> (proto_err && $stable(col_addr)));

  assert_status_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && chunk_kind == KIND_RDATA && (cmd_st == CMD_STATUS || cfm_st == CMD_STATUS))
      |=> $stable(col_addr));

  assert_rd_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && chunk_kind == KIND_RDATA && cmd_st != CMD_STATUS &&
     cfm_st != CMD_STATUS && cfm_st != CMD_READ) |=> (proto_err && $stable(rd_data)));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_vld && chunk_kind == KIND_CMD && known) |=> !proto_err);

endmodule

bind nand_tgt_decoder nand_tgt_decoder_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .chunk_vld  (chunk_vld),
  .chunk_kind (chunk_kind),
  .chunk_byte (chunk_byte),
  .ptr        (ptr),
  .cmd_st     (cmd_st),
  .cfm_st     (cfm_st),
  .proto_err  (proto_err),
  .col_addr   (col_addr),
  .rd_data    (rd_data)
);

// File: tb/nand_tgt_decoder_tb.sv
`timescale 1ns/1ps
module nand_tgt_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chunk_vld = 1'b0;
  logic [1:0] chunk_kind = 2'd0;
  logic [7:0] chunk_byte = 8'h00;
  logic [7:0] rd_data;
  logic       proto_err;
  logic [3:0] col_addr;
  logic [2:0] page_addr;
  logic [3:0] block_addr;
  logic [0:0] lun_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [2][16];

  always #2.5 clk = ~clk;

  nand_tgt_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .chunk_vld(chunk_vld), .chunk_kind(chunk_kind),
    .chunk_byte(chunk_byte), .rd_data(rd_data), .proto_err(proto_err),
    .col_addr(col_addr), .page_addr(page_addr), .block_addr(block_addr), .lun_addr(lun_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    chunk_vld  = 1'b1;
    chunk_kind = k;
    chunk_byte = b;
    @(negedge clk);
    chunk_vld  = 1'b0;
  endtask

  function automatic logic [7:0] row_lo(input int pg, input int blk, input int ln);
    return 8'(pg | (blk << 3) | (ln << 7));
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 proto_err", proto_err, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 col", col_addr, 0);
    chk("R1 page", page_addr, 0);
    chk("R1 block", block_addr, 0);
    chk("R1 lun", lun_addr, 0);
    send(2'd3, 8'h00);
    chk("R1 read after reset rejected", proto_err, 1);
    chk("R1 rd_data held", rd_data, 0);
    send(2'd0, 8'hFF);
    chk("R9 command clears error", proto_err, 0);
    send(2'd1, 8'h77);
    chk("R1 pointer full after reset", proto_err, 1);
    chk("R9 address ignored", page_addr, 0);

    // R6 program both LUN page registers fully
    for (int ln = 0; ln < 2; ln++) begin
      send(2'd0, 8'h80);
      chk("R9 program command clears error", proto_err, 0);
      send(2'd1, 8'h00);
      send(2'd1, 8'hA0);
      send(2'd1, row_lo(2 + ln, 9 - ln, ln));
      send(2'd1, 8'h5A);
      send(2'd1, 8'hC3);
      chk("R4 page", page_addr, 2 + ln);
      chk("R4 block", block_addr, 9 - ln);
      chk("R4 lun", lun_addr, ln);
      chk("R4 column from slots 0 1", col_addr, 0);
      send(2'd0, 8'h80);
      for (int i = 0; i < 16; i++) begin
        exp_mem[ln][i] = 8'((ln * 37 + i * 11 + 5) & 255);
        send(2'd2, exp_mem[ln][i]);
        chk("R6 column step", col_addr, (i + 1) % 16);
      end
      chk("R6 no error on writes", proto_err, 0);
    end

    // R8 status on active LUN 1 after program
    send(2'd0, 8'h70);
    send(2'd3, 8'h00);
    chk("R8 status lun1 program", rd_data, 8'h42);
    chk("R8 column unchanged", col_addr, 0);

    // R7 read LUN 0 from column 3, wrapping
    send(2'd0, 8'h00);
    send(2'd1, 8'h03);
    send(2'd1, 8'hFF);
    send(2'd1, row_lo(2, 9, 0));
    send(2'd1, 8'h11);
    send(2'd1, 8'h22);
    chk("R4 column truncated", col_addr, 3);
    send(2'd0, 8'h00);
    chk("R5 confirm accepted", proto_err, 0);
    for (int i = 0; i < 16; i++) begin
      send(2'd3, 8'h00);
      chk("R7 R10 read data", rd_data, exp_mem[0][(3 + i) % 16]);
      chk("R7 column step", col_addr, (4 + i) % 16);
    end

    // R6 R9 write rejected under read confirm
    send(2'd2, 8'hEE);
    chk("R6 write rejected", proto_err, 1);
    chk("R9 column held", col_addr, 3);
    send(2'd3, 8'h00);
    chk("R9 page byte untouched", rd_data, exp_mem[0][3]);
    chk("R9 error sticky", proto_err, 1);

    // R2 R3 erase: three slots only
    send(2'd0, 8'hFF);
    chk("R9 reset clears error", proto_err, 0);
    send(2'd0, 8'h60);
    send(2'd1, row_lo(1, 5, 1));
    send(2'd1, 8'h00);
    send(2'd1, 8'h00);
    chk("R2 erase needs three slots", proto_err, 0);
    chk("R4 erase lun", lun_addr, 1);
    chk("R4 stale column slots", col_addr, 3);
    send(2'd1, 8'h44);
    chk("R3 fourth erase address rejected", proto_err, 1);
    chk("R3 block unchanged", block_addr, 5);
    send(2'd0, 8'h60);
    send(2'd0, 8'h70);
    send(2'd3, 8'h00);
    chk("R8 status lun1 erase", rd_data, 8'h43);

    // R5 status as confirm, then new command
    send(2'd0, 8'h00);
    send(2'd1, 8'h00);
    send(2'd1, 8'h00);
    send(2'd1, row_lo(2, 9, 0));
    send(2'd1, 8'h00);
    send(2'd1, 8'h00);
    send(2'd0, 8'h70);
    send(2'd3, 8'h00);
    chk("R5 R8 status confirm lun0", rd_data, 8'h41);
    chk("R8 column held", col_addr, 0);
    send(2'd0, 8'h00);
    send(2'd3, 8'h00);
    chk("R5 second command starts new op", proto_err, 1);
    chk("R9 rd_data held", rd_data, 8'h41);

    // R5 Reset byte never confirms
    send(2'd1, 8'h00);
    send(2'd1, 8'h00);
    send(2'd1, row_lo(0, 0, 1));
    send(2'd1, 8'h00);
    send(2'd1, 8'h00);
    send(2'd0, 8'hFF);
    send(2'd3, 8'h00);
    chk("R5 reset is not a confirm", proto_err, 1);

    // R9 undefined command code ignored
    send(2'd0, 8'h70);
    chk("R9 status clears error", proto_err, 0);
    send(2'd0, 8'h12);
    chk("R9 unknown code flags", proto_err, 1);
    send(2'd3, 8'h00);
    chk("R9 R10 command kept, lun1 status", rd_data, 8'h43);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule